// File: doc/BRIEF.md
# Posted Interrupt Recording Engine

This block takes interrupt requests that carry a source identifier and a remapping index. It looks up the index in a small internal remapping table and, for entries in posted format, sets the entry's virtual-vector bit in the 256-bit pending bitmap of the per-vCPU descriptor that the entry points at. Each vCPU owns one descriptor, so the entry's pointer chooses the destination vCPU. The engine then decides whether to raise a notification event. The event carries the vector and the destination ID held in that descriptor.

Descriptors sit in an internal array with a masked write port and a combinational read port. Through this port a consumer fills in the notification vector and destination, sets or clears the suppress flag, drains pending bits and acknowledges the outstanding flag. Requests are taken one at a time with a valid/ready handshake. The pending-bit update and the outstanding-flag test-and-set complete in the single cycle of acceptance. The engine holds a request back when the descriptor port writes the same descriptor in that cycle. Multicast/broadcast requests, entries in remapped format, and missing or non-present entries never touch a descriptor.

Top module: `pir_post_engine`

## Requirements
- R1: After reset no pulse output is high, every descriptor reads as all zeros, every table entry is non-present, and `req_ready` is high while the descriptor port is idle.
- R2: A table write stores an entry encoded as bit 0 present, bit 1 fault-processing-disable, bit 2 posted format, bit 3 urgent, bits 11:4 virtual vector and the bits above 11 the descriptor pointer. The entry is used by every request accepted after the write edge.
- R3: An accepted request whose entry is in range, present and in posted format, and which is not multicast, sets pending bit V (descriptor bits 255:0, V = the entry's virtual vector) in the pointed descriptor. It leaves every other pending bit unchanged.
- R4: Such a request issues a notification only when the outstanding flag (descriptor bit 256) was 0. The same edge sets the flag to 1. The engine never clears the flag.
- R5: When the suppress flag (descriptor bit 257) is 1, a non-urgent request records its bit without notifying. An urgent request notifies whatever the suppress flag holds.
- R6: A notification is a one-cycle `ntf_valid` pulse in the cycle after acceptance. It carries descriptor bits 279:272 as the vector and bits 319:288 as the destination.
- R7: A request with `req_mcast` high that hits a valid posted entry produces a one-cycle `rej_pulse` and changes no descriptor.
- R8: An index at or above the table depth, or an index that hits a non-present entry, produces a one-cycle `flt_pulse` with the index and source ID. A non-present entry whose fault-processing-disable bit is 1 produces no pulse at all. None of these changes a descriptor.
- R9: A present entry in remapped (non-posted) format produces `rej_pulse` and changes no descriptor.
- R10: A descriptor port write replaces exactly the bits selected by `dport_mask` with `dport_wdata`. `dport_rdata` shows the descriptor at `dport_addr` combinationally.
- R11: `req_ready` is low while the descriptor port writes the descriptor that the indexed present entry points at. A write to another descriptor does not stall the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken this cycle |
| req_index | input | REQ_IDX_W (8) | Remapping index |
| req_src | input | SRC_W (16) | Source identifier |
| req_mcast | input | 1 | Request is multicast or broadcast |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | TAW (4) | Table entry to write |
| tbl_wdata | input | ENT_W (14) | Encoded entry (see R2) |
| dport_we | input | 1 | Descriptor masked write strobe |
| dport_addr | input | PTR_W (2) | Descriptor to read/write |
| dport_mask | input | 320 | Bit-select for the write |
| dport_wdata | input | 320 | Write data |
| dport_rdata | output | 320 | Descriptor contents |
| ntf_valid | output | 1 | Notification pulse |
| ntf_vector | output | 8 | Notification vector |
| ntf_dest | output | 32 | Notification destination ID |
| rej_pulse | output | 1 | Request was not postable |
| flt_pulse | output | 1 | Fault on lookup |
| flt_index | output | REQ_IDX_W (8) | Index of the faulting request |
| flt_src | output | SRC_W (16) | Source of the faulting request |

## Verification
A fault in the outstanding-flag handling shows up in the first request after the flag changes. Either a second notification appears without an acknowledge, or a notification goes missing after the consumer clears the flag. A wrong pending-bit index or lost update reads back at `dport_rdata` at once, one cycle after acceptance. Errors in the suppress/urgent gating, the reject paths and the fault paths appear on the pulse outputs in the cycle after acceptance. Sequences that acknowledge, change the suppress flag and mix urgent with non-urgent entries expose these faults.

// File: rtl/pir_pkg.sv
package pir_pkg;
   localparam int VEC_W   = 8;
   localparam int NUM_VEC = 1 << VEC_W;
   localparam int DEST_W  = 32;
   localparam int DESC_W  = 320;
   localparam int ON_BIT  = NUM_VEC;       // outstanding flag
   localparam int SN_BIT  = NUM_VEC + 1;   // suppress flag
   localparam int NV_LSB  = 272;
   localparam int DST_LSB = 288;
   // table entry field positions
   localparam int E_PRES  = 0;
   localparam int E_FPD   = 1;
   localparam int E_POST  = 2;
   localparam int E_URG   = 3;
   localparam int E_VLSB  = 4;
   localparam int E_PLSB  = E_VLSB + VEC_W;
endpackage

// File: rtl/pir_remap_table.sv
module pir_remap_table
   import pir_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int IDX_W = 8,
   parameter int PTR_W = 2,
   localparam int AW    = $clog2(DEPTH),
   localparam int ENT_W = E_PLSB + PTR_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [ENT_W-1:0] wr_data,
   input  logic [IDX_W-1:0] lk_idx,
   output logic             lk_in_range,
   output logic             lk_present,
   output logic             lk_fpd,
   output logic             lk_posted,
   output logic             lk_urg,
   output logic [VEC_W-1:0] lk_vec,
   output logic [PTR_W-1:0] lk_ptr
);
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("pir_remap_table: DEPTH must be a power of two, at least 2");
   end
   if (IDX_W < AW) begin : g_bad_idx
      $error("pir_remap_table: IDX_W too narrow for DEPTH");
   end

   logic [ENT_W-1:0] mem [DEPTH];
   logic [ENT_W-1:0] ent;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   if (IDX_W == AW) begin : g_full_range
      assign lk_in_range = 1'b1;
   end else begin : g_part_range
      assign lk_in_range = (lk_idx < IDX_W'(DEPTH));
   end

   assign ent        = mem[lk_idx[AW-1:0]];
   assign lk_present = lk_in_range & ent[E_PRES];
   assign lk_fpd     = lk_in_range & ent[E_FPD];
   assign lk_posted  = ent[E_POST];
   assign lk_urg     = ent[E_URG];
   assign lk_vec     = ent[E_VLSB +: VEC_W];
   assign lk_ptr     = ent[E_PLSB +: PTR_W];

   // R2: a written entry is stored as given
   a_r2_entry_stored: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/pir_desc_array.sv
module pir_desc_array
   import pir_pkg::*;
#(
   parameter int NUM_DESC = 4,
   localparam int PTR_W = $clog2(NUM_DESC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              usr_we,
   input  logic [PTR_W-1:0]  usr_addr,
   input  logic [DESC_W-1:0] usr_mask,
   input  logic [DESC_W-1:0] usr_wdata,
   output logic [DESC_W-1:0] usr_rdata,
   input  logic [PTR_W-1:0]  eng_addr,
   input  logic              eng_we,
   input  logic [VEC_W-1:0]  eng_vec,
   input  logic              eng_set_on,
   output logic              eng_on,
   output logic              eng_sn,
   output logic [VEC_W-1:0]  eng_nv,
   output logic [DEST_W-1:0] eng_dest
);
   if (NUM_DESC < 2 || (1 << PTR_W) != NUM_DESC) begin : g_bad_num
      $error("pir_desc_array: NUM_DESC must be a power of two, at least 2");
   end

   logic [DESC_W-1:0] mem [NUM_DESC];
   logic [DESC_W-1:0] eng_word;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_DESC; i++) mem[i] <= '0;
      end else begin
         for (int i = 0; i < NUM_DESC; i++) begin
            if (eng_we && eng_addr == PTR_W'(i)) begin
               mem[i][eng_vec] <= 1'b1;
               if (eng_set_on) mem[i][ON_BIT] <= 1'b1;
            end else if (usr_we && usr_addr == PTR_W'(i)) begin
               mem[i] <= (mem[i] & ~usr_mask) | (usr_wdata & usr_mask);
            end
         end
      end
   end

   assign usr_rdata = mem[usr_addr];
   assign eng_word  = mem[eng_addr];
   assign eng_on    = eng_word[ON_BIT];
   assign eng_sn    = eng_word[SN_BIT];
   assign eng_nv    = eng_word[NV_LSB +: VEC_W];
   assign eng_dest  = eng_word[DST_LSB +: DEST_W];

   // R11: engine update and port write never hit one descriptor together
   a_r11_no_collision: assert property (@(posedge clk) disable iff (!rst_n)
      !(eng_we && usr_we && eng_addr == usr_addr));
   // R3: posted vector bit is set after the update edge
   a_r3_bit_recorded: assert property (@(posedge clk) disable iff (!rst_n)
      eng_we |=> mem[$past(eng_addr)][$past(eng_vec)]);
   // R4: outstanding flag is set together with a notification
   a_r4_on_set: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_we && eng_set_on) |=> mem[$past(eng_addr)][ON_BIT]);
endmodule

// File: rtl/pir_post_ctrl.sv
module pir_post_ctrl
   import pir_pkg::*;
#(
   parameter int IDX_W = 8,
   parameter int SRC_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [IDX_W-1:0]  req_index,
   input  logic [SRC_W-1:0]  req_src,
   input  logic              req_mcast,
   output logic              req_ready,
   input  logic              lk_in_range,
   input  logic              lk_present,
   input  logic              lk_fpd,
   input  logic              lk_posted,
   input  logic              lk_urg,
   input  logic              port_conflict,
   input  logic              d_on,
   input  logic              d_sn,
   input  logic [VEC_W-1:0]  d_nv,
   input  logic [DEST_W-1:0] d_dest,
   output logic              eng_we,
   output logic              eng_set_on,
   output logic              ntf_valid,
   output logic [VEC_W-1:0]  ntf_vector,
   output logic [DEST_W-1:0] ntf_dest,
   output logic              rej_pulse,
   output logic              flt_pulse,
   output logic [IDX_W-1:0]  flt_index,
   output logic [SRC_W-1:0]  flt_src
);
   logic usable, post_ok, fault_c, reject_c, accept, send;

   assign usable    = lk_in_range & lk_present;
   assign post_ok   = usable & lk_posted & ~req_mcast;
   assign reject_c  = usable & (req_mcast | ~lk_posted);
   assign fault_c   = ~usable & ~lk_fpd;
   assign req_ready = ~(usable & port_conflict);
   assign accept    = req_valid & req_ready;
   assign send      = ~d_on & (lk_urg | ~d_sn);

   assign eng_we     = accept & post_ok;
   assign eng_set_on = eng_we & send;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ntf_valid  <= 1'b0;
         ntf_vector <= '0;
         ntf_dest   <= '0;
         rej_pulse  <= 1'b0;
         flt_pulse  <= 1'b0;
         flt_index  <= '0;
         flt_src    <= '0;
      end else begin
         ntf_valid <= eng_set_on;
         rej_pulse <= accept & reject_c;
         flt_pulse <= accept & fault_c;
         if (eng_set_on) begin
            ntf_vector <= d_nv;
            ntf_dest   <= d_dest;
         end
         if (accept & fault_c) begin
            flt_index <= req_index;
            flt_src   <= req_src;
         end
      end
   end

   // R7, R8, R9: at most one outcome pulse per request
   a_r7_outcome_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ntf_valid, rej_pulse, flt_pulse}));
   // R6: notification only follows a posting acceptance
   a_r6_notify_after_post: assert property (@(posedge clk) disable iff (!rst_n)
      ntf_valid |-> $past(eng_we));
endmodule

// File: rtl/pir_post_engine.sv
module pir_post_engine
   import pir_pkg::*;
#(
   parameter int TBL_DEPTH = 16,
   parameter int NUM_DESC  = 4,
   parameter int REQ_IDX_W = 8,
   parameter int SRC_W     = 16,
   localparam int TAW   = $clog2(TBL_DEPTH),
   localparam int PTR_W = $clog2(NUM_DESC),
   localparam int ENT_W = E_PLSB + PTR_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [REQ_IDX_W-1:0] req_index,
   input  logic [SRC_W-1:0]     req_src,
   input  logic                 req_mcast,
   input  logic                 tbl_we,
   input  logic [TAW-1:0]       tbl_addr,
   input  logic [ENT_W-1:0]     tbl_wdata,
   input  logic                 dport_we,
   input  logic [PTR_W-1:0]     dport_addr,
   input  logic [DESC_W-1:0]    dport_mask,
   input  logic [DESC_W-1:0]    dport_wdata,
   output logic [DESC_W-1:0]    dport_rdata,
   output logic                 ntf_valid,
   output logic [VEC_W-1:0]     ntf_vector,
   output logic [DEST_W-1:0]    ntf_dest,
   output logic                 rej_pulse,
   output logic                 flt_pulse,
   output logic [REQ_IDX_W-1:0] flt_index,
   output logic [SRC_W-1:0]     flt_src
);
   logic             lk_in_range, lk_present, lk_fpd, lk_posted, lk_urg;
   logic [VEC_W-1:0] lk_vec;
   logic [PTR_W-1:0] lk_ptr;
   logic             d_on, d_sn;
   logic [VEC_W-1:0] d_nv;
   logic [DEST_W-1:0] d_dest;
   logic             eng_we, eng_set_on, conflict;

   assign conflict = dport_we & (dport_addr == lk_ptr);

   pir_remap_table #(.DEPTH(TBL_DEPTH), .IDX_W(REQ_IDX_W), .PTR_W(PTR_W)) u_tbl (
      .clk, .rst_n,
      .wr_en(tbl_we), .wr_addr(tbl_addr), .wr_data(tbl_wdata),
      .lk_idx(req_index), .lk_in_range, .lk_present, .lk_fpd,
      .lk_posted, .lk_urg, .lk_vec, .lk_ptr
   );

   pir_desc_array #(.NUM_DESC(NUM_DESC)) u_desc (
      .clk, .rst_n,
      .usr_we(dport_we), .usr_addr(dport_addr), .usr_mask(dport_mask),
      .usr_wdata(dport_wdata), .usr_rdata(dport_rdata),
      .eng_addr(lk_ptr), .eng_we, .eng_vec(lk_vec), .eng_set_on,
      .eng_on(d_on), .eng_sn(d_sn), .eng_nv(d_nv), .eng_dest(d_dest)
   );

   pir_post_ctrl #(.IDX_W(REQ_IDX_W), .SRC_W(SRC_W)) u_ctrl (
      .clk, .rst_n,
      .req_valid, .req_index, .req_src, .req_mcast, .req_ready,
      .lk_in_range, .lk_present, .lk_fpd, .lk_posted, .lk_urg,
      .port_conflict(conflict),
      .d_on, .d_sn, .d_nv, .d_dest,
      .eng_we, .eng_set_on,
      .ntf_valid, .ntf_vector, .ntf_dest,
      .rej_pulse, .flt_pulse, .flt_index, .flt_src
   );
endmodule

// File: tb/pir_post_engine_tb.sv
module pir_post_engine_tb;
   localparam int DW = 320;
   logic clk = 0, rst_n = 0;
   logic req_valid = 0, req_mcast = 0, tbl_we = 0, dport_we = 0;
   logic [7:0] req_index = 0;
   logic [15:0] req_src = 0;
   logic [3:0] tbl_addr = 0;
   logic [13:0] tbl_wdata = 0;
   logic [1:0] dport_addr = 0;
   logic [DW-1:0] dport_mask = 0, dport_wdata = 0;
   logic req_ready, ntf_valid, rej_pulse, flt_pulse;
   logic [DW-1:0] dport_rdata;
   logic [7:0] ntf_vector, flt_index;
   logic [31:0] ntf_dest;
   logic [15:0] flt_src;
   int n_run = 0, n_fail = 0;
   logic s_ntf, s_rej, s_flt;
   logic [7:0] s_vec, s_fidx;
   logic [31:0] s_dest;
   logic [15:0] s_fsrc;

   always #5 clk = ~clk;

   pir_post_engine u_dut (.*);

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr_entry(input int idx, input bit pres, input bit fpd, input bit post,
                           input bit urg, input logic [7:0] vec, input logic [1:0] ptr);
      @(negedge clk);
      tbl_we = 1; tbl_addr = 4'(idx);
      tbl_wdata = {ptr, vec, urg, post, fpd, pres};
      @(posedge clk); #1 tbl_we = 0;
   endtask

   task automatic wr_desc(input logic [1:0] a, input logic [DW-1:0] m, input logic [DW-1:0] d);
      @(negedge clk);
      dport_we = 1; dport_addr = a; dport_mask = m; dport_wdata = d;
      @(posedge clk); #1 dport_we = 0;
   endtask

   task automatic rd_desc(input logic [1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      dport_addr = a; #1 d = dport_rdata;
   endtask

   task automatic send(input logic [7:0] idx, input bit mc, input logic [15:0] src);
      @(negedge clk);
      req_valid = 1; req_index = idx; req_mcast = mc; req_src = src;
      @(posedge clk); #1;
      s_ntf = ntf_valid; s_rej = rej_pulse; s_flt = flt_pulse;
      s_vec = ntf_vector; s_dest = ntf_dest; s_fidx = flt_index; s_fsrc = flt_src;
      req_valid = 0;
   endtask

   task automatic t_reset();
      logic [DW-1:0] d;
      @(negedge clk);
      chk("R1 no notify", DW'(ntf_valid), 0);
      chk("R1 no pulses", DW'({rej_pulse, flt_pulse}), 0);
      chk("R1 ready", DW'(req_ready), 1);
      rd_desc(0, d); chk("R1 desc clear", d, 0);
      send(8'd2, 0, 16'h1);
      chk("R1 entry non-present faults", DW'(s_flt), 1);
   endtask

   task automatic t_basic();
      logic [DW-1:0] d, m, w;
      m = '0; w = '0;
      m[279:272] = '1; w[279:272] = 8'h40; m[319:288] = '1; w[319:288] = 32'h11;
      wr_desc(0, m, w);
      wr_entry(3, 1, 0, 1, 0, 8'h25, 2'd0);
      send(8'd3, 0, 16'hA);
      chk("R6 notify pulse", DW'(s_ntf), 1);
      chk("R6 vector", DW'(s_vec), 8'h40);
      chk("R6 dest", DW'(s_dest), 32'h11);
      rd_desc(0, d);
      chk("R3 bit 37", DW'(d[255:0]), DW'(1) << 37);
      chk("R4 on set", DW'(d[256]), 1);
      @(posedge clk); #1 chk("R6 single pulse", DW'(ntf_valid), 0);
   endtask

   task automatic t_outstanding();
      logic [DW-1:0] d, m;
      wr_entry(4, 1, 0, 1, 0, 8'hFF, 2'd0);
      send(8'd4, 0, 16'hB);
      chk("R4 no second notify", DW'(s_ntf), 0);
      rd_desc(0, d);
      chk("R3 bit 255 added", DW'(d[255:0]), (DW'(1) << 37) | (DW'(1) << 255));
      chk("R4 on kept", DW'(d[256]), 1);
      m = '0; m[256] = 1;
      wr_desc(0, m, '0);
      rd_desc(0, d);
      chk("R10 ack only clears on", DW'({d[256], d[279:272]}), DW'({1'b0, 8'h40}));
      send(8'd3, 0, 16'hB);
      chk("R4 notify after ack", DW'(s_ntf), 1);
   endtask

   task automatic t_suppress();
      logic [DW-1:0] d, m, w;
      m = '0; w = '0;
      m[257] = 1; w[257] = 1;
      m[279:272] = '1; w[279:272] = 8'h7A; m[319:288] = '1; w[319:288] = 32'hDEADBEEF;
      wr_desc(3, m, w);
      wr_entry(5, 1, 0, 1, 0, 8'h00, 2'd3);
      wr_entry(6, 1, 0, 1, 1, 8'h01, 2'd3);
      send(8'd5, 0, 16'hC);
      chk("R5 suppressed", DW'(s_ntf), 0);
      rd_desc(3, d);
      chk("R5 recorded bit0, on clear", DW'({d[256], d[1:0]}), 3'b001);
      send(8'd6, 0, 16'hC);
      chk("R5 urgent notifies", DW'(s_ntf), 1);
      chk("R6 urgent vec/dest", DW'({s_vec, s_dest}), DW'({8'h7A, 32'hDEADBEEF}));
      rd_desc(3, d);
      chk("R4 on set via urgent", DW'({d[256], d[1:0]}), 3'b111);
   endtask

   task automatic t_reject();
      logic [DW-1:0] d;
      wr_entry(7, 1, 0, 1, 1, 8'h80, 2'd1);
      send(8'd7, 1, 16'hD);
      chk("R7 multicast reject", DW'({s_rej, s_ntf, s_flt}), 3'b100);
      rd_desc(1, d); chk("R7 no record", d, 0);
      wr_entry(10, 1, 0, 0, 1, 8'h33, 2'd1);
      send(8'd10, 0, 16'hD);
      chk("R9 remapped reject", DW'({s_rej, s_ntf, s_flt}), 3'b100);
      rd_desc(1, d); chk("R9 no record", d, 0);
   endtask

   task automatic t_fault();
      wr_entry(9, 0, 1, 1, 1, 8'h44, 2'd1);
      send(8'd8, 0, 16'h1234);
      chk("R8 non-present fault", DW'({s_flt, s_fidx, s_fsrc}), DW'({1'b1, 8'd8, 16'h1234}));
      send(8'd9, 0, 16'h5);
      chk("R8 fpd silences", DW'({s_rej, s_ntf, s_flt}), 0);
      send(8'd200, 0, 16'h77);
      chk("R8 out-of-range fault", DW'({s_flt, s_fidx, s_fsrc}), DW'({1'b1, 8'd200, 16'h77}));
   endtask

   task automatic t_conflict();
      logic [DW-1:0] d;
      @(negedge clk);
      req_valid = 1; req_index = 8'd3; req_mcast = 0;
      dport_we = 1; dport_addr = 2'd0; dport_mask = '0; dport_wdata = '0;
      #1 chk("R11 stall same desc", DW'(req_ready), 0);
      dport_addr = 2'd2;
      #1 chk("R11 other desc no stall", DW'(req_ready), 1);
      dport_addr = 2'd0;
      @(posedge clk); #1;
      chk("R11 no pulse while stalled", DW'({ntf_valid, rej_pulse, flt_pulse}), 0);
      dport_we = 0; req_valid = 0;
      dport_mask = '0; dport_mask[7:0] = '1; dport_wdata = '0; dport_wdata[7:0] = 8'hA5;
      wr_desc(2, dport_mask, dport_wdata);
      rd_desc(2, d); chk("R10 masked write", d, DW'(8'hA5));
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      t_reset();
      t_basic();
      t_outstanding();
      t_suppress();
      t_reject();
      t_fault();
      t_conflict();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule